// File: doc/BRIEF.md
# Slow-Clock Time Counter with Coherent Snapshot Readout

This block keeps a free-running time counter in the slow real-time clock domain and lets software on the fast bus clock read it safely. Software does not read the moving counter. It writes a request bit in a control register. The block passes that request into the slow domain, captures the counter there, and sends an acknowledgement back to the fast domain. The acknowledgement copies the captured value into a fast-domain snapshot and raises a valid flag.

Software polls the valid flag and then reads the snapshot as two 32-bit words. The snapshot changes only when a capture completes, so the low and high words always belong to the same counter value. A request that arrives while a capture is still in flight joins that capture and does not start a second one. The valid flag is cleared by a separate clear bit, and a new request also clears it.

Top module: `rtcs_snapshot_top`

## Requirements
- R1: After reset, the control/status word, the low snapshot word and the high snapshot word all read as zero.
- R2: The counter is zero after slow-domain reset and adds one on each slow-clock rising edge. A captured value lies between the number of slow edges counted when the request was written and that number plus 3.
- R3: Writing register 0 with bit 0 set makes the next status read show pending (bit 1) set and valid (bit 0) clear.
- R4: After a request, valid reads as 1 and pending as 0 within 4 slow-clock periods plus 4 fast-clock cycles. Valid and pending are never both set.
- R5: Writing register 0 with bit 1 set (and bit 0 clear) clears valid. The snapshot words are left unchanged.
- R6: A request written while a capture is pending starts no new capture. That capture completes exactly once, and its value is bounded by the first request.
- R7: The snapshot words hold their value until the next capture completes. This includes the time while a newer request is still pending.
- R8: Read map. Address 0 returns {30'b0, pending, valid}. Address 1 returns counter bits 31:0 of the snapshot. Address 2 returns snapshot bits 63:32, with bits above the counter width reading zero. Address 3 returns zero.
- R9: Writes to addresses 1, 2 and 3 change neither the status nor the snapshot.
- R10: A write to register 0 with both bit 0 and bit 1 set acts as a request. Pending is set, valid is cleared, and the capture completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fast | input | 1 | Bus clock |
| rst_fast_n | input | 1 | Asynchronous active-low reset, fast domain |
| clk_slow | input | 1 | Slow real-time clock |
| rst_slow_n | input | 1 | Asynchronous active-low reset, slow domain |
| reg_wr_en | input | 1 | Write strobe for one fast cycle |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr, combinational |

## Verification
The bench keeps its own count of slow-clock edges and brackets each captured value between the count at the request and that count plus three. A design that samples the counter at the wrong point in the handshake, or returns an old value, falls outside that window. Two requests written back to back check the merge rule: a design that sends a second toggle cancels the first in the synchronizer and never raises valid. The bench also reads the snapshot while a newer request is pending and long after a capture, so a design that updates the snapshot before the acknowledgement shows a changed low word. Writes to the data addresses and a combined request-and-clear write are checked too; a wrong address decode shows up as changed status or a changed snapshot.

// File: rtl/rtcs_pkg.sv
package rtcs_pkg;

    typedef enum logic [1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_LO   = 2'd1,
        ADDR_HI   = 2'd2,
        ADDR_RSV  = 2'd3
    } reg_addr_e;

    // control write bits
    localparam int CTRL_REQ_BIT = 0;
    localparam int CTRL_CLR_BIT = 1;

    // status read bits
    localparam int STAT_VALID_BIT = 0;
    localparam int STAT_PEND_BIT  = 1;

endpackage

// File: rtl/rtcs_sync.sv
module rtcs_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] st_d, st_q;

    always_comb begin
        st_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            st_d[i] = st_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/rtcs_slow_core.sv
module rtcs_slow_core #(
    parameter int CNT_W = 48
) (
    input  logic             clk_slow,
    input  logic             rst_slow_n,
    input  logic             req_tgl_sync_i,
    output logic [CNT_W-1:0] snap_o,
    output logic             ack_tgl_o,
    output logic [CNT_W-1:0] cnt_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] snap;
        logic             req_last;
        logic             ack_tgl;
    } slow_st_t;

    slow_st_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.cnt      = st_q.cnt + CNT_W'(1);
        st_d.req_last = req_tgl_sync_i;
        if (req_tgl_sync_i != st_q.req_last) begin
            st_d.snap    = st_q.cnt;
            st_d.ack_tgl = ~st_q.ack_tgl;
        end
    end

    always_ff @(posedge clk_slow or negedge rst_slow_n) begin
        if (!rst_slow_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign snap_o    = st_q.snap;
    assign ack_tgl_o = st_q.ack_tgl;
    assign cnt_o     = st_q.cnt;
endmodule

// File: rtl/rtcs_fast_regs.sv
module rtcs_fast_regs
    import rtcs_pkg::*;
#(
    parameter int CNT_W  = 48,
    parameter int DATA_W = 32
) (
    input  logic              clk_fast,
    input  logic              rst_fast_n,
    input  logic              wr_en_i,
    input  logic [1:0]        addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic              ack_tgl_sync_i,
    input  logic [CNT_W-1:0]  snap_slow_i,
    output logic              req_tgl_o,
    output logic              valid_o,
    output logic              pending_o,
    output logic              ack_evt_o,
    output logic [CNT_W-1:0]  shadow_o
);
    typedef struct packed {
        logic             ack_last;
        logic             req_tgl;
        logic             pending;
        logic             valid;
        logic [CNT_W-1:0] shadow;
    } fast_st_t;

    fast_st_t st_d, st_q;
    logic ctrl_wr, req_wr, clr_wr, ack_evt;
    logic [DATA_W-1:0] hi_word;
    logic unused_wdata_bits;

    assign unused_wdata_bits = ^wdata_i;
    assign ctrl_wr = wr_en_i && (reg_addr_e'(addr_i) == ADDR_CTRL);
    assign req_wr  = ctrl_wr && wdata_i[CTRL_REQ_BIT];
    assign clr_wr  = ctrl_wr && wdata_i[CTRL_CLR_BIT];
    assign ack_evt = ack_tgl_sync_i ^ st_q.ack_last;

    // priority: clear, then completion, then new request
    always_comb begin
        st_d          = st_q;
        st_d.ack_last = ack_tgl_sync_i;
        if (clr_wr) begin
            st_d.valid = 1'b0;
        end
        if (ack_evt) begin
            st_d.shadow  = snap_slow_i;
            st_d.pending = 1'b0;
            st_d.valid   = 1'b1;
        end
        if (req_wr) begin
            st_d.valid = 1'b0;
            if (!st_d.pending) begin
                st_d.req_tgl = ~st_q.req_tgl;
                st_d.pending = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_fast or negedge rst_fast_n) begin
        if (!rst_fast_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    generate
        if (CNT_W > DATA_W) begin : g_hi
            assign hi_word = DATA_W'(st_q.shadow[CNT_W-1:DATA_W]);
        end else begin : g_no_hi
            assign hi_word = '0;
        end
    endgenerate

    always_comb begin
        rdata_o = '0;
        unique case (reg_addr_e'(addr_i))
            ADDR_CTRL: begin
                rdata_o[STAT_VALID_BIT] = st_q.valid;
                rdata_o[STAT_PEND_BIT]  = st_q.pending;
            end
            ADDR_LO:  rdata_o = st_q.shadow[DATA_W-1:0];
            ADDR_HI:  rdata_o = hi_word;
            ADDR_RSV: rdata_o = '0;
            default:  rdata_o = '0;
        endcase
    end

    assign req_tgl_o = st_q.req_tgl;
    assign valid_o   = st_q.valid;
    assign pending_o = st_q.pending;
    assign ack_evt_o = ack_evt;
    assign shadow_o  = st_q.shadow;
endmodule

// File: rtl/rtcs_snapshot_top.sv
module rtcs_snapshot_top #(
    parameter int CNT_W       = 48,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_fast,
    input  logic              rst_fast_n,
    input  logic              clk_slow,
    input  logic              rst_slow_n,
    input  logic              reg_wr_en,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata
);
    logic             req_tgl_w, req_tgl_slow_w;
    logic             ack_tgl_w, ack_tgl_fast_w;
    logic [CNT_W-1:0] snap_w, cnt_w, shadow_w;
    logic             valid_w, pending_w, ack_evt_w;

    rtcs_sync #(.W(1), .STAGES(SYNC_STAGES)) req_sync_i (
        .clk   (clk_slow),
        .rst_n (rst_slow_n),
        .d_i   (req_tgl_w),
        .q_o   (req_tgl_slow_w)
    );

    rtcs_slow_core #(.CNT_W(CNT_W)) slow_i (
        .clk_slow       (clk_slow),
        .rst_slow_n     (rst_slow_n),
        .req_tgl_sync_i (req_tgl_slow_w),
        .snap_o         (snap_w),
        .ack_tgl_o      (ack_tgl_w),
        .cnt_o          (cnt_w)
    );

    rtcs_sync #(.W(1), .STAGES(SYNC_STAGES)) ack_sync_i (
        .clk   (clk_fast),
        .rst_n (rst_fast_n),
        .d_i   (ack_tgl_w),
        .q_o   (ack_tgl_fast_w)
    );

    rtcs_fast_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) regs_i (
        .clk_fast       (clk_fast),
        .rst_fast_n     (rst_fast_n),
        .wr_en_i        (reg_wr_en),
        .addr_i         (reg_addr),
        .wdata_i        (reg_wdata),
        .rdata_o        (reg_rdata),
        .ack_tgl_sync_i (ack_tgl_fast_w),
        .snap_slow_i    (snap_w),
        .req_tgl_o      (req_tgl_w),
        .valid_o        (valid_w),
        .pending_o      (pending_w),
        .ack_evt_o      (ack_evt_w),
        .shadow_o       (shadow_w)
    );
endmodule

// File: rtl/rtcs_checker.sv
module rtcs_checker #(
    parameter int CNT_W  = 48,
    parameter int DATA_W = 32
) (
    input logic              clk_fast,
    input logic              rst_fast_n,
    input logic              clk_slow,
    input logic              rst_slow_n,
    input logic              reg_wr_en,
    input logic [1:0]        reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              valid,
    input logic              pending,
    input logic              ack_evt,
    input logic [CNT_W-1:0]  shadow,
    input logic [CNT_W-1:0]  cnt
);
    p_cnt_step_r2: assert property (@(posedge clk_slow) disable iff (!rst_slow_n)
        1'b1 |=> (cnt == CNT_W'($past(cnt) + CNT_W'(1))));

    p_req_clears_valid_r3: assert property (@(posedge clk_fast) disable iff (!rst_fast_n)
        (reg_wr_en && reg_addr == 2'd0 && reg_wdata[0]) |=> (pending && !valid));

    p_valid_pending_excl_r4: assert property (@(posedge clk_fast) disable iff (!rst_fast_n)
        !(valid && pending));

    p_valid_rise_after_pending_r4: assert property (@(posedge clk_fast) disable iff (!rst_fast_n)
        $rose(valid) |-> $past(pending));

    p_clear_drops_valid_r5: assert property (@(posedge clk_fast) disable iff (!rst_fast_n)
        (reg_wr_en && reg_addr == 2'd0 && reg_wdata[1] && !ack_evt) |=> !valid);

    p_ack_only_pending_r6: assert property (@(posedge clk_fast) disable iff (!rst_fast_n)
        ack_evt |-> pending);

    p_snap_hold_r7: assert property (@(posedge clk_fast) disable iff (!rst_fast_n)
        !ack_evt |=> $stable(shadow));
endmodule

bind rtcs_snapshot_top rtcs_checker #(.CNT_W(CNT_W), .DATA_W(DATA_W)) chk_i (
    .clk_fast   (clk_fast),
    .rst_fast_n (rst_fast_n),
    .clk_slow   (clk_slow),
    .rst_slow_n (rst_slow_n),
    .reg_wr_en  (reg_wr_en),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .valid      (valid_w),
    .pending    (pending_w),
    .ack_evt    (ack_evt_w),
    .shadow     (shadow_w),
    .cnt        (cnt_w)
);

// File: tb/rtcs_snapshot_top_tb_top.sv
module rtcs_snapshot_top_tb_top;
    localparam int DATA_W = 32;
    localparam int POLL_LIMIT = 67; // 4 slow periods + 4 fast cycles, in fast cycles

    logic clk_fast = 1'b0;
    logic clk_slow = 1'b0;
    logic rst_fast_n = 1'b0;
    logic rst_slow_n = 1'b0;
    logic reg_wr_en = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;

    int checks = 0;
    int fails = 0;
    int slow_edges = 0;
    int req_edges = 0;
    bit finished = 1'b0;

    always #10 clk_fast = ~clk_fast;
    always #157 clk_slow = ~clk_slow;

    always @(posedge clk_slow) if (rst_slow_n) slow_edges++;

    rtcs_snapshot_top dut_i (
        .clk_fast   (clk_fast),
        .rst_fast_n (rst_fast_n),
        .clk_slow   (clk_slow),
        .rst_slow_n (rst_slow_n),
        .reg_wr_en  (reg_wr_en),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk_fast);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr_en = 1'b1;
        @(posedge clk_fast);
        #1;
        req_edges = slow_edges;
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [DATA_W-1:0] d);
        @(negedge clk_fast);
        reg_addr = a;
        #2;
        d = reg_rdata;
    endtask

    task automatic wait_valid(output bit ok);
        logic [DATA_W-1:0] s;
        ok = 1'b0;
        for (int i = 0; i < POLL_LIMIT; i++) begin
            reg_read(2'd0, s);
            if (s[0]) begin
                ok = 1'b1;
                break;
            end
        end
    endtask

    task automatic t_reset();
        logic [DATA_W-1:0] d;
        reg_read(2'd0, d); check(d == 0, "R1 status", d, 0);
        reg_read(2'd1, d); check(d == 0, "R1 low", d, 0);
        reg_read(2'd2, d); check(d == 0, "R1 high", d, 0);
        reg_read(2'd3, d); check(d == 0, "R8 reserved", d, 0);
    endtask

    task automatic t_single(output longint v);
        logic [DATA_W-1:0] d;
        int n0;
        bit ok;
        reg_write(2'd0, 32'h1);
        n0 = req_edges;
        reg_read(2'd0, d); check(d == 2, "R3 pending set valid clear", d, 2);
        wait_valid(ok); check(ok, "R4 valid within bound", ok, 1);
        reg_read(2'd0, d); check(d == 1, "R4 status after capture", d, 1);
        reg_read(2'd1, d); v = d;
        check(v >= n0 && v <= n0 + 3, "R2 capture window (lower bound shown)", v, n0);
        reg_read(2'd2, d); check(d == 0, "R8 high word", d, 0);
    endtask

    task automatic t_stable(input longint v);
        logic [DATA_W-1:0] d;
        repeat (20) @(posedge clk_slow);
        reg_read(2'd1, d); check(d == v, "R7 snapshot held", d, v);
        reg_read(2'd0, d); check(d == 1, "R7 valid held", d, 1);
    endtask

    task automatic t_clear(input longint v);
        logic [DATA_W-1:0] d;
        reg_write(2'd0, 32'h2);
        reg_read(2'd0, d); check(d == 0, "R5 valid cleared", d, 0);
        reg_read(2'd1, d); check(d == v, "R5 snapshot kept", d, v);
    endtask

    task automatic t_merge(output longint v);
        logic [DATA_W-1:0] d;
        int n0;
        bit ok;
        reg_write(2'd0, 32'h1);
        n0 = req_edges;
        reg_write(2'd0, 32'h1);
        wait_valid(ok); check(ok, "R6 merged request completes", ok, 1);
        reg_read(2'd1, d); v = d;
        check(v >= n0 && v <= n0 + 3, "R6 value from first request", v, n0);
        repeat (10) @(posedge clk_slow);
        reg_read(2'd0, d); check(d == 1, "R6 no second capture status", d, 1);
        reg_read(2'd1, d); check(d == v, "R6 no second capture value", d, v);
    endtask

    task automatic t_hold_pending(input longint vp);
        logic [DATA_W-1:0] d;
        bit ok;
        reg_write(2'd0, 32'h1);
        reg_read(2'd0, d); check(d == 2, "R3 request clears set valid", d, 2);
        reg_read(2'd1, d); check(d == vp, "R7 old value while pending", d, vp);
        reg_read(2'd1, d); check(d == vp, "R7 old value while pending again", d, vp);
        wait_valid(ok); check(ok, "R4 completion", ok, 1);
        reg_read(2'd1, d); check(longint'(d) > vp, "R2 later capture larger", d, vp + 1);
    endtask

    task automatic t_ignored();
        logic [DATA_W-1:0] d, lo, st;
        reg_read(2'd1, lo);
        reg_read(2'd0, st);
        reg_write(2'd1, 32'hFFFF_FFFF);
        reg_write(2'd2, 32'hFFFF_FFFF);
        reg_write(2'd3, 32'h3);
        reg_read(2'd0, d); check(d == st, "R9 status unchanged", d, st);
        reg_read(2'd1, d); check(d == lo, "R9 low unchanged", d, lo);
        reg_read(2'd2, d); check(d == 0, "R9 high unchanged", d, 0);
    endtask

    task automatic t_both_bits();
        logic [DATA_W-1:0] d;
        int n0;
        bit ok;
        reg_write(2'd0, 32'h3);
        n0 = req_edges;
        reg_read(2'd0, d); check(d == 2, "R10 combined write requests", d, 2);
        wait_valid(ok); check(ok, "R10 combined write completes", ok, 1);
        reg_read(2'd1, d);
        check(d >= n0 && d <= n0 + 3, "R10 capture window", d, n0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        longint v1, v2;
        #1003 rst_slow_n = 1'b1;
        #40;
        @(negedge clk_fast);
        rst_fast_n = 1'b1;
        t_reset();
        t_single(v1);
        t_stable(v1);
        t_clear(v1);
        t_merge(v2);
        check(v2 > v1, "R2 counter advances", v2, v1 + 1);
        t_hold_pending(v2);
        t_ignored();
        t_both_bits();
        finish_run();
    end

    initial begin
        #4000000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule